// File: doc/BRIEF.md
# Extended CRTC Timing Generator

This block produces the horizontal and vertical timing of a display. One free-running counter steps once per character clock across a line, and a second counter steps once per line across a frame. Programmed compare values turn the two counts into horizontal blank, horizontal sync, vertical blank, vertical sync and a display-enable window. Both counts are also driven out for the rest of the display pipe.

The horizontal fields are 9 bits wide and the vertical fields are 11 bits wide. Each blank or sync pulse ends on a match of a few low counter bits only, so the width of a pulse is limited, not its position. Timing is always taken from a working-set register bank. That bank has two write ports: a standard path and an extension path. A lock input picks the mode. When the lock is low, the working set follows standard-path writes. When the lock is high, only extension-path writes reach it. Extension writes are accepted in both modes.

Top module: `crtc_timing_gen`

## Requirements
- R1: The character counter runs 0, 1, ... up to (horizontal total field + 4), then returns to 0, so a line lasts total+5 character clocks (a field of 95 gives 100). The line counter advances in the clock where the character counter returns to 0, and at no other time.
- R2: The line counter returns to 0 after it reaches (vertical total field + 1), so a frame lasts total+2 lines.
- R3: hblank is high in any clock where the character counter equals the 9-bit blank-start field. Once high, it stays high until a clock where the counter's low 6 bits equal the 6-bit blank-end field; it is low in that clock. A start match wins over an end match. A pulse may run across the end of a line.
- R4: hsync follows the same rule as R3, using the 9-bit sync-start field and a 5-bit sync-end match on the counter's low 5 bits.
- R5: vblank is high on a line whose number equals the 11-bit vertical blank-start field. Once high, it stays high until a line whose low 8 bits equal the 8-bit blank-end field.
- R6: Vertical sync follows the same rule as R5, using the 11-bit sync-start field and a 4-bit end match on the line number's low 4 bits. The vsync pin carries this pulse when vsync_invert is 0 and its inverse when vsync_invert is 1.
- R7: disp_en is high exactly when the character counter is below the 9-bit horizontal display-end field and the line counter is below the 11-bit vertical display-end field.
- R8: Working-set field indices are:
  - 0 horizontal total
  - 1 horizontal display end
  - 2 horizontal blank start
  - 3 horizontal blank end
  - 4 horizontal sync start
  - 5 horizontal sync end
  - 6 vertical total
  - 7 vertical display end
  - 8 vertical blank start
  - 9 vertical blank end
  - 10 vertical sync start
  - 11 vertical sync end

  Each write stores the low bits of the write data, as many as the field is wide. Writes to indices 12 to 15 change nothing. With ws_lock at 0, a standard-path write updates the addressed field at the next clock edge. An extension-path write does the same in either mode.
- R9: With ws_lock at 1, standard-path writes leave the working set unchanged. If both ports write in the same clock, only the extension write takes effect.
- R10: While rst_n is low at a clock edge, both counters and every working-set field are cleared to 0. With cleared fields a line lasts 5 clocks and disp_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ws_lock | input | 1 | 1: only extension writes reach the working set |
| vsync_invert | input | 1 | 1: vsync pin is driven inverted |
| std_we | input | 1 | Standard-path write strobe |
| std_addr | input | 4 | Standard-path field index |
| std_wdata | input | 11 | Standard-path write data |
| ext_we | input | 1 | Extension-path write strobe |
| ext_addr | input | 4 | Extension-path field index |
| ext_wdata | input | 11 | Extension-path write data |
| hblank | output | 1 | Horizontal blank |
| hsync | output | 1 | Horizontal sync, active high |
| vblank | output | 1 | Vertical blank |
| vsync | output | 1 | Vertical sync, polarity set by vsync_invert |
| disp_en | output | 1 | Display enable |
| hcnt | output | 9 | Character counter |
| vcnt | output | 11 | Line counter |

## Verification
The hardest case to reach from the ports is a standard-path write that has been locked out. The working set cannot be read, so the ignored write can only be seen in later timing. The stimulus first programs a 100-character line, then raises the lock and writes a new total through the standard path. It then measures the next full line period at hcnt and expects it to stay at 100. After that, an extension write and a same-clock write on both ports must each change the measured period. A blank pulse that starts late in one line and ends early in the next is reached by placing the start near the line total and the end match a few characters into the next line.

// File: rtl/crtc_pkg.sv
// Shared widths, field indices and the working-set layout of the timing generator.
package crtc_pkg;
    localparam int HW   = 9;   // horizontal position fields
    localparam int VW   = 11;  // vertical position fields
    localparam int HBEW = 6;   // horizontal blank end match width
    localparam int HSEW = 5;   // horizontal sync end match width
    localparam int VBEW = 8;   // vertical blank end match width
    localparam int VSEW = 4;   // vertical sync end match width
    localparam int AW   = 4;   // field index width
    localparam int DW   = VW;  // write data width (widest field)

    typedef enum logic [AW-1:0] {
        IDX_HTOT = 4'd0,
        IDX_HDE  = 4'd1,
        IDX_HBS  = 4'd2,
        IDX_HBE  = 4'd3,
        IDX_HSS  = 4'd4,
        IDX_HSE  = 4'd5,
        IDX_VTOT = 4'd6,
        IDX_VDE  = 4'd7,
        IDX_VBS  = 4'd8,
        IDX_VBE  = 4'd9,
        IDX_VSS  = 4'd10,
        IDX_VSE  = 4'd11
    } crtc_idx_e;

    typedef struct packed {
        logic [HW-1:0]   htot;
        logic [HW-1:0]   hde;
        logic [HW-1:0]   hbs;
        logic [HBEW-1:0] hbe;
        logic [HW-1:0]   hss;
        logic [HSEW-1:0] hse;
        logic [VW-1:0]   vtot;
        logic [VW-1:0]   vde;
        logic [VW-1:0]   vbs;
        logic [VBEW-1:0] vbe;
        logic [VW-1:0]   vss;
        logic [VSEW-1:0] vse;
    } crtc_ws_t;
endpackage

// File: rtl/crtc_regbank.sv
// Working-set register bank.
// Merges the standard and extension write ports into one field write.
// Assumes: the extension port always wins, and a standard write is dropped while lock is high.
module crtc_regbank
    import crtc_pkg::*;
#(
    parameter int ADDR_W = AW,
    parameter int DATA_W = DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              std_we,
    input  logic [ADDR_W-1:0] std_addr,
    input  logic [DATA_W-1:0] std_wdata,
    input  logic              ext_we,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [DATA_W-1:0] ext_wdata,
    output crtc_ws_t          ws
);
    logic              sel_we;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_data;

    // Pick the winning write port for this clock.
    always_comb begin
        sel_we   = ext_we | (std_we & ~lock);
        sel_addr = ext_we ? ext_addr  : std_addr;
        sel_data = ext_we ? ext_wdata : std_wdata;
    end

    // Store the selected field, truncated to the field width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws <= '0;
        end else if (sel_we) begin
            case (crtc_idx_e'(sel_addr))
                IDX_HTOT: ws.htot <= sel_data[HW-1:0];
                IDX_HDE:  ws.hde  <= sel_data[HW-1:0];
                IDX_HBS:  ws.hbs  <= sel_data[HW-1:0];
                IDX_HBE:  ws.hbe  <= sel_data[HBEW-1:0];
                IDX_HSS:  ws.hss  <= sel_data[HW-1:0];
                IDX_HSE:  ws.hse  <= sel_data[HSEW-1:0];
                IDX_VTOT: ws.vtot <= sel_data[VW-1:0];
                IDX_VDE:  ws.vde  <= sel_data[VW-1:0];
                IDX_VBS:  ws.vbs  <= sel_data[VW-1:0];
                IDX_VBE:  ws.vbe  <= sel_data[VBEW-1:0];
                IDX_VSS:  ws.vss  <= sel_data[VW-1:0];
                IDX_VSE:  ws.vse  <= sel_data[VSEW-1:0];
                default: ;
            endcase
        end
    end

    // A locked standard write with no extension write leaves the bank unchanged.
    assert_lock_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && std_we && !ext_we) |=> $stable(ws));

    // An extension write to the total field lands at the next edge.
    assert_ext_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_we && ext_addr == ADDR_W'(IDX_HTOT)) |=> (ws.htot == $past(ext_wdata[HW-1:0])));
endmodule

// File: rtl/crtc_hcount.sv
// Horizontal character counter with blank, sync and active-window decode.
// A pulse starts on a full-width position match.
// It ends on a low-bit match that is tested every clock.
// Assumes: the totals come from the working set and may change at any clock.
module crtc_hcount #(
    parameter int W    = 9,
    parameter int BEW  = 6,
    parameter int SEW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   htot,
    input  logic [W-1:0]   hde,
    input  logic [W-1:0]   hbs,
    input  logic [BEW-1:0] hbe,
    input  logic [W-1:0]   hss,
    input  logic [SEW-1:0] hse,
    output logic [W-1:0]   hcnt,
    output logic           line_end,
    output logic           hblank,
    output logic           hsync,
    output logic           hactive
);
    localparam int WX = W + 1;

    logic [WX-1:0] last_pos;
    logic          hb_held;
    logic          hs_held;

    // Last character position of the line and the pulse decodes.
    always_comb begin
        last_pos = {1'b0, htot} + WX'(4);
        line_end = ({1'b0, hcnt} >= last_pos);
        hblank   = (hcnt == hbs) | (hb_held & (hcnt[BEW-1:0] != hbe));
        hsync    = (hcnt == hss) | (hs_held & (hcnt[SEW-1:0] != hse));
        hactive  = (hcnt < hde);
    end

    // Step the character counter and remember the pulse levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt    <= '0;
            hb_held <= 1'b0;
            hs_held <= 1'b0;
        end else begin
            hcnt    <= line_end ? '0 : hcnt + 1'b1;
            hb_held <= hblank;
            hs_held <= hsync;
        end
    end

    // The counter either steps by one or restarts at zero.
    assert_hcnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt == W'($past(hcnt) + 1'b1)) || (hcnt == '0));

    // Blank can only rise on a start match.
    assert_hblank_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hblank) |-> (hcnt == hbs));

    // Blank can only fall on an end match.
    assert_hblank_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hblank) |-> (hcnt[BEW-1:0] == hbe));

    // Sync can only fall on an end match.
    assert_hsync_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync) |-> (hcnt[SEW-1:0] == hse));
endmodule

// File: rtl/crtc_vcount.sv
// Vertical line counter with blank, sync and active-window decode.
// Pulse levels are remembered only at line boundaries.
// Assumes: adv pulses once per line, in the last character clock of the line.
module crtc_vcount #(
    parameter int W    = 11,
    parameter int BEW  = 8,
    parameter int SEW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adv,
    input  logic [W-1:0]   vtot,
    input  logic [W-1:0]   vde,
    input  logic [W-1:0]   vbs,
    input  logic [BEW-1:0] vbe,
    input  logic [W-1:0]   vss,
    input  logic [SEW-1:0] vse,
    output logic [W-1:0]   vcnt,
    output logic           vblank,
    output logic           vsync_act,
    output logic           vactive
);
    localparam int WX = W + 1;

    logic [WX-1:0] last_line;
    logic          frame_end;
    logic          vb_held;
    logic          vs_held;

    // Last line of the frame and the pulse decodes.
    always_comb begin
        last_line = {1'b0, vtot} + WX'(1);
        frame_end = ({1'b0, vcnt} >= last_line);
        vblank    = (vcnt == vbs) | (vb_held & (vcnt[BEW-1:0] != vbe));
        vsync_act = (vcnt == vss) | (vs_held & (vcnt[SEW-1:0] != vse));
        vactive   = (vcnt < vde);
    end

    // Step the line counter at each line end and remember the pulse levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcnt    <= '0;
            vb_held <= 1'b0;
            vs_held <= 1'b0;
        end else if (adv) begin
            vcnt    <= frame_end ? '0 : vcnt + 1'b1;
            vb_held <= vblank;
            vs_held <= vsync_act;
        end
    end

    // The line number changes only after a line-end clock.
    assert_vcnt_moves_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (vcnt != $past(vcnt)) |-> $past(adv));

    // A change of the line number is a step of one or a return to zero.
    assert_vcnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (vcnt != $past(vcnt)) |-> ((vcnt == W'($past(vcnt) + 1'b1)) || (vcnt == '0)));
endmodule

// File: rtl/crtc_timing_gen.sv
// Top of the extended display timing generator.
// Joins the working-set bank, the horizontal counter and the vertical counter.
// It also sets the vsync polarity and the display-enable window.
// Assumes: one clock per character and synchronous active-low reset.
module crtc_timing_gen
    import crtc_pkg::*;
#(
    parameter int ADDR_W = AW,
    parameter int DATA_W = DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ws_lock,
    input  logic              vsync_invert,
    input  logic              std_we,
    input  logic [ADDR_W-1:0] std_addr,
    input  logic [DATA_W-1:0] std_wdata,
    input  logic              ext_we,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [DATA_W-1:0] ext_wdata,
    output logic              hblank,
    output logic              hsync,
    output logic              vblank,
    output logic              vsync,
    output logic              disp_en,
    output logic [HW-1:0]     hcnt,
    output logic [VW-1:0]     vcnt
);
    crtc_ws_t ws;
    logic     line_end;
    logic     hactive;
    logic     vactive;
    logic     vsync_act;

    crtc_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock      (ws_lock),
        .std_we    (std_we),
        .std_addr  (std_addr),
        .std_wdata (std_wdata),
        .ext_we    (ext_we),
        .ext_addr  (ext_addr),
        .ext_wdata (ext_wdata),
        .ws        (ws)
    );

    crtc_hcount #(.W(HW), .BEW(HBEW), .SEW(HSEW)) u_h (
        .clk      (clk),
        .rst_n    (rst_n),
        .htot     (ws.htot),
        .hde      (ws.hde),
        .hbs      (ws.hbs),
        .hbe      (ws.hbe),
        .hss      (ws.hss),
        .hse      (ws.hse),
        .hcnt     (hcnt),
        .line_end (line_end),
        .hblank   (hblank),
        .hsync    (hsync),
        .hactive  (hactive)
    );

    crtc_vcount #(.W(VW), .BEW(VBEW), .SEW(VSEW)) u_v (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (line_end),
        .vtot      (ws.vtot),
        .vde       (ws.vde),
        .vbs       (ws.vbs),
        .vbe       (ws.vbe),
        .vss       (ws.vss),
        .vse       (ws.vse),
        .vcnt      (vcnt),
        .vblank    (vblank),
        .vsync_act (vsync_act),
        .vactive   (vactive)
    );

    // Apply the vsync polarity and combine the two active windows.
    always_comb begin
        vsync   = vsync_act ^ vsync_invert;
        disp_en = hactive & vactive;
    end

    // Display enable is never high outside the horizontal window.
    assert_de_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en |-> (hcnt < ws.hde));
endmodule

// File: tb/tb_crtc_timing_gen.sv
// Directed bench for crtc_timing_gen.
// A requirement-level model of the timing is compared with the outputs every clock.
module tb_crtc_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ws_lock = 1'b0;
    logic        vsync_invert = 1'b0;
    logic        std_we = 1'b0;
    logic [3:0]  std_addr = '0;
    logic [10:0] std_wdata = '0;
    logic        ext_we = 1'b0;
    logic [3:0]  ext_addr = '0;
    logic [10:0] ext_wdata = '0;
    logic        hblank, hsync, vblank, vsync, disp_en;
    logic [8:0]  hcnt;
    logic [10:0] vcnt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int mreg [12];
    int mh, mv;
    bit mhb, mhs, mvb, mvs;

    always #10 clk = ~clk;

    crtc_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .ws_lock(ws_lock), .vsync_invert(vsync_invert),
        .std_we(std_we), .std_addr(std_addr), .std_wdata(std_wdata),
        .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .hblank(hblank), .hsync(hsync), .vblank(vblank), .vsync(vsync),
        .disp_en(disp_en), .hcnt(hcnt), .vcnt(vcnt)
    );

    function automatic int fmask(int idx);
        case (idx)
            3:       return 63;
            5:       return 31;
            6, 7, 8, 10: return 2047;
            9:       return 255;
            11:      return 15;
            default: return 511;
        endcase
    endfunction

    function automatic bit e_hb();
        return (mh == mreg[2]) || (mhb && ((mh & 63) != mreg[3]));
    endfunction
    function automatic bit e_hs();
        return (mh == mreg[4]) || (mhs && ((mh & 31) != mreg[5]));
    endfunction
    function automatic bit e_vb();
        return (mv == mreg[8]) || (mvb && ((mv & 255) != mreg[9]));
    endfunction
    function automatic bit e_vs();
        return (mv == mreg[10]) || (mvs && ((mv & 15) != mreg[11]));
    endfunction
    function automatic bit e_de();
        return (mh < mreg[1]) && (mv < mreg[7]);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d (h=%0d v=%0d)", req, what, act, exp, hcnt, vcnt);
        end
    endtask

    task automatic compare_all();
        chk("R1", "hcnt", int'(hcnt), mh);
        chk("R2", "vcnt", int'(vcnt), mv);
        chk("R3", "hblank", int'(hblank), int'(e_hb()));
        chk("R4", "hsync", int'(hsync), int'(e_hs()));
        chk("R5", "vblank", int'(vblank), int'(e_vb()));
        chk("R6", "vsync", int'(vsync), int'(e_vs() ^ vsync_invert));
        chk("R7", "disp_en", int'(disp_en), int'(e_de()));
    endtask

    // One clock: advance the model at the edge, then compare at the falling edge.
    task automatic cyc();
        bit b_hb, b_hs, b_vb, b_vs, lend;
        @(posedge clk);
        if (!rst_n) begin
            mh = 0; mv = 0; mhb = 0; mhs = 0; mvb = 0; mvs = 0;
            for (int i = 0; i < 12; i++) mreg[i] = 0;
        end else begin
            b_hb = e_hb(); b_hs = e_hs(); b_vb = e_vb(); b_vs = e_vs();
            lend = (mh >= mreg[0] + 4);
            mhb = b_hb; mhs = b_hs;
            if (lend) begin
                mvb = b_vb; mvs = b_vs;
                mv = (mv >= mreg[6] + 1) ? 0 : ((mv + 1) & 2047);
                mh = 0;
            end else begin
                mh = (mh + 1) & 511;
            end
            if (ext_we) begin
                if (ext_addr < 12) mreg[ext_addr] = int'(ext_wdata) & fmask(int'(ext_addr));
            end else if (std_we && !ws_lock) begin
                if (std_addr < 12) mreg[std_addr] = int'(std_wdata) & fmask(int'(std_addr));
            end
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr_std(int idx, int val);
        std_we = 1'b1; std_addr = 4'(idx); std_wdata = 11'(val);
        cyc();
        std_we = 1'b0;
    endtask

    task automatic wr_ext(int idx, int val);
        ext_we = 1'b1; ext_addr = 4'(idx); ext_wdata = 11'(val);
        cyc();
        ext_we = 1'b0;
    endtask

    task automatic wait_at(string req, int h, int v);
        for (int i = 0; i < 6000; i++) begin
            if (int'(hcnt) == h && int'(vcnt) == v) return;
            cyc();
        end
        chk(req, "reach position", 0, 1);
    endtask

    task automatic measure_line(string req, int exp);
        int n = 0;
        for (int i = 0; i < 700 && hcnt == 0; i++) cyc();
        for (int i = 0; i < 700 && hcnt != 0; i++) cyc();
        cyc(); n = 1;
        for (int i = 0; i < 700 && hcnt != 0; i++) begin cyc(); n++; end
        chk(req, "line period", n, exp);
    endtask

    // R10: reset clears counters and fields.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        chk("R10", "hcnt after reset", int'(hcnt), 0);
        chk("R10", "vcnt after reset", int'(vcnt), 0);
        chk("R10", "disp_en after reset", int'(disp_en), 0);
        measure_line("R10", 5);
    endtask

    // R8, R1: program through the standard path and measure a 100-character line.
    task automatic t_std_program();
        wr_std(6, 10); wr_std(7, 8); wr_std(8, 8); wr_std(9, 11);
        wr_std(10, 9); wr_std(11, 11);
        wr_std(0, 95); wr_std(1, 80); wr_std(2, 82); wr_std(3, 34);
        wr_std(4, 85); wr_std(5, 29);
        wr_std(13, 3);
        measure_line("R8", 100);
        measure_line("R1", 100);
    endtask

    // R2: 12-line frame.
    task automatic t_frame();
        wait_at("R2", 0, 11);
        repeat (99) cyc();
        chk("R2", "last position line", int'(vcnt), 11);
        chk("R2", "last position char", int'(hcnt), 99);
        cyc();
        chk("R2", "frame wrap", int'(vcnt), 0);
    endtask

    // R3: blank runs across the line end and stops on the low-bit match.
    task automatic t_hblank();
        wr_std(2, 90); wr_std(3, 46);
        wait_at("R3", 10, 2);
        chk("R3", "blank carried into line", int'(hblank), 1);
        wait_at("R3", 45, 2);
        chk("R3", "blank before end", int'(hblank), 1);
        cyc();
        chk("R3", "blank at end match", int'(hblank), 0);
        wait_at("R3", 89, 2);
        chk("R3", "blank before start", int'(hblank), 0);
        cyc();
        chk("R3", "blank at start", int'(hblank), 1);
    endtask

    // R4: horizontal sync window 85..92.
    task automatic t_hsync();
        wait_at("R4", 84, 3);
        chk("R4", "sync before start", int'(hsync), 0);
        cyc();
        chk("R4", "sync at start", int'(hsync), 1);
        wait_at("R4", 92, 3);
        chk("R4", "sync before end", int'(hsync), 1);
        cyc();
        chk("R4", "sync at end match", int'(hsync), 0);
    endtask

    // R5, R6, R7: vertical pulses and the display window.
    task automatic t_vert();
        wait_at("R7", 0, 0);  chk("R7", "de top left", int'(disp_en), 1);
        wait_at("R7", 79, 7); chk("R7", "de last char", int'(disp_en), 1);
        cyc();                chk("R7", "de past h end", int'(disp_en), 0);
        wait_at("R5", 0, 8);  chk("R5", "vblank start", int'(vblank), 1);
                              chk("R6", "vsync before start", int'(vsync), 0);
        wait_at("R7", 10, 8); chk("R7", "de past v end", int'(disp_en), 0);
        wait_at("R6", 0, 9);  chk("R6", "vsync start", int'(vsync), 1);
        wait_at("R5", 50, 10); chk("R5", "vblank held", int'(vblank), 1);
                              chk("R6", "vsync held", int'(vsync), 1);
        wait_at("R5", 0, 11); chk("R5", "vblank end match", int'(vblank), 0);
                              chk("R6", "vsync end match", int'(vsync), 0);
    endtask

    // R6: inverted polarity.
    task automatic t_polarity();
        vsync_invert = 1'b1;
        wait_at("R6", 3, 9); chk("R6", "inverted sync active", int'(vsync), 0);
        wait_at("R6", 3, 5); chk("R6", "inverted sync idle", int'(vsync), 1);
        vsync_invert = 1'b0;
        cyc();
    endtask

    // R9, R8: lock mode and port priority.
    task automatic t_lock();
        ws_lock = 1'b1;
        wr_std(0, 20);
        measure_line("R9", 100);
        wr_ext(0, 45);
        measure_line("R9", 50);
        ws_lock = 1'b0;
        std_we = 1'b1; std_addr = 4'd0; std_wdata = 11'd30;
        ext_we = 1'b1; ext_addr = 4'd0; ext_wdata = 11'd60;
        cyc();
        std_we = 1'b0; ext_we = 1'b0;
        measure_line("R9", 65);
        wr_std(0, 95);
        measure_line("R8", 100);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_std_program();
        t_frame();
        t_hblank();
        t_hsync();
        t_vert();
        t_polarity();
        t_lock();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule